// File: doc/BRIEF.md
# Unlock-Guarded Clock Synthesizer Configuration Registers

This block holds the settings that steer an on-chip frequency synthesizer: which reference oscillator feeds it, the pre-divider and loop multiplier values, and whether the synthesizer runs and drives the system clock. Software reaches it through a simple single-cycle register port. The source selection applies as soon as it is written. The divider, multiplier, run and connect settings are first held in a staging copy. They reach the synthesizer outputs only after a two-write unlock on the key register.

A reset leaves the synthesizer stopped and bypassed. So does the power-down input. The power-down input also clears the staged run and connect requests, so software must write them again before the synthesizer can restart. A status register shows the values that are in force and the loop-lock input. This lets software see the difference between the staged and active settings.

The register port has no back-pressure. An access is taken on every clock edge where `bus_req` is high. A read returns its data on `bus_rdata` one cycle later, marked by `bus_rvalid`.

Top module: `clkctl_regs`

## Requirements
- R1: After reset, `src_sel`=0, `div_n_m1`=0, `mul_m_m1`=0, `syn_en`=0 and `syn_connect`=0.
- R2: A write to address 0 updates `src_sel` with `bus_wdata[1:0]` at that clock edge. Code 0 selects the internal RC oscillator, 1 the main oscillator and 2 the low-frequency crystal oscillator.
- R3: A write of code 3 to address 0 is ignored, and `src_sel` keeps its previous value. A read of address 0 returns the selection in bits [1:0] with all higher bits zero.
- R4: A write to address 1 (configuration) or address 2 (control) changes only the staged copy. `div_n_m1`, `mul_m_m1`, `syn_en` and `syn_connect` do not change until the unlock completes.
- R5: A write of 0xAA to address 3 (key), with the very next access being a write of 0x55 to address 3, copies the staged values to the outputs at the edge of the 0x55 write.
- R6: Any other access between the two key writes cancels the unlock, and the 0x55 write then has no effect. This includes a read, a write to another address, or a key write of another value.
- R7: `syn_connect` is set by an unlock only if the staged connect and run bits are set, `syn_en` is already 1 before that unlock, and `lock_i` is high.
- R8: With `pd_i` high, `syn_en` and `syn_connect` are 0 from the next edge. The staged run and connect bits are cleared, so a later unlock alone does not restart the synthesizer.
- R9: Reads of addresses 1 and 2 return the staged values. A read of address 4 returns the active values and `lock_i`. `bus_rvalid` is 1 in the cycle after a read access and 0 otherwise.
- R10: The configuration word carries M-1 in bits [14:0] and N-1 in bits [23:16]. The control word carries run in bit 0 and connect in bit 1. The status word carries M-1 in [14:0], N-1 in [23:16], run in bit 24, connect in bit 25 and lock in bit 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access strobe, taken every cycle it is high |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Marks valid read data |
| lock_i | input | 1 | Synthesizer loop locked |
| pd_i | input | 1 | Power-down request |
| src_sel | output | 2 | Active reference source code |
| div_n_m1 | output | 8 | Active pre-divider value minus one |
| mul_m_m1 | output | 15 | Active multiplier value minus one |
| syn_en | output | 1 | Synthesizer run |
| syn_connect | output | 1 | Synthesizer drives the clock (0 = bypass) |

## Verification
Every write result is due at the clock edge that takes the write. This holds for a source change and for the copy made by the second key write. Power-down shows at the next edge, and read data with its valid flag appear one edge after the read. The bench drives each access at a falling edge and samples a quarter period after the following rising edge, so each check sees exactly one new edge's worth of change. Vector steps with no expected change confirm that staged writes and broken unlocks leave the outputs untouched.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam logic [2:0] A_SRC  = 3'd0;
  localparam logic [2:0] A_CFG  = 3'd1;
  localparam logic [2:0] A_CTL  = 3'd2;
  localparam logic [2:0] A_KEY  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam logic [1:0] SRC_BAD = 2'b11;
endpackage

// File: rtl/clkctl_src.sv
module clkctl_src (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] code,
  output logic [1:0] sel
);
  import clkctl_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     sel <= 2'b00;
    else if (wr && code != SRC_BAD) sel <= code;
  end

  a_r3_bad_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && code == SRC_BAD) |=> $stable(sel));
  a_r3_never_bad: assert property (@(posedge clk) disable iff (!rst_n)
    sel != SRC_BAD);
endmodule

// File: rtl/clkctl_feed.sv
module clkctl_feed (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [7:0] wbyte,
  output logic       apply
);
  import clkctl_pkg::*;

  logic armed;
  logic key_wr;

  assign key_wr = acc && we && (addr == A_KEY);
  assign apply  = armed && key_wr && (wbyte == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   armed <= 1'b0;
    else if (acc) armed <= key_wr && (wbyte == KEY_FIRST);
  end

  a_r6_break_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !(key_wr && wbyte == KEY_FIRST)) |=> !apply);
endmodule

// File: rtl/clkctl_stage.sv
module clkctl_stage #(
  parameter int NW = 8,
  parameter int MW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          ctl_we,
  input  logic [NW-1:0] wr_n,
  input  logic [MW-1:0] wr_m,
  input  logic          wr_en,
  input  logic          wr_cn,
  input  logic          apply,
  input  logic          pd,
  input  logic          lock,
  output logic [NW-1:0] stg_n,
  output logic [MW-1:0] stg_m,
  output logic          stg_en,
  output logic          stg_cn,
  output logic [NW-1:0] act_n,
  output logic [MW-1:0] act_m,
  output logic          act_en,
  output logic          act_cn
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_n <= '0;
      stg_m <= '0;
    end else if (cfg_we) begin
      stg_n <= wr_n;
      stg_m <= wr_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_en <= 1'b0;
      stg_cn <= 1'b0;
    end else if (pd) begin
      stg_en <= 1'b0;
      stg_cn <= 1'b0;
    end else if (ctl_we) begin
      stg_en <= wr_en;
      stg_cn <= wr_cn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_n  <= '0;
      act_m  <= '0;
      act_en <= 1'b0;
      act_cn <= 1'b0;
    end else if (pd) begin
      act_en <= 1'b0;
      act_cn <= 1'b0;
    end else if (apply) begin
      act_n  <= stg_n;
      act_m  <= stg_m;
      act_en <= stg_en;
      act_cn <= stg_cn && stg_en && act_en && lock;
    end
  end

  a_r7_connect_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_cn) |-> $past(act_en && lock));
  a_r8_powerdown_off: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (!act_en && !act_cn && !stg_en));
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs #(
  parameter int DW = 32,
  parameter int NW = 8,
  parameter int MW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  input  logic          lock_i,
  input  logic          pd_i,
  output logic [1:0]    src_sel,
  output logic [NW-1:0] div_n_m1,
  output logic [MW-1:0] mul_m_m1,
  output logic          syn_en,
  output logic          syn_connect
);
  import clkctl_pkg::*;

  localparam int N_LSB  = ((MW + 7) / 8) * 8;
  localparam int EN_BIT = N_LSB + NW;
  localparam int CN_BIT = EN_BIT + 1;
  localparam int LK_BIT = EN_BIT + 2;

  logic          wr;
  logic          apply;
  logic [NW-1:0] stg_n;
  logic [MW-1:0] stg_m;
  logic          stg_en, stg_cn;
  logic [DW-1:0] rd_next;
  logic          unused_wbits;

  assign wr           = bus_req && bus_we;
  assign unused_wbits = ^bus_wdata;

  clkctl_src u_src (
    .clk (clk), .rst_n (rst_n),
    .wr  (wr && bus_addr == A_SRC),
    .code(bus_wdata[1:0]),
    .sel (src_sel)
  );

  clkctl_feed u_feed (
    .clk  (clk), .rst_n (rst_n),
    .acc  (bus_req), .we (bus_we), .addr (bus_addr),
    .wbyte(bus_wdata[7:0]),
    .apply(apply)
  );

  clkctl_stage #(.NW(NW), .MW(MW)) u_stage (
    .clk   (clk), .rst_n (rst_n),
    .cfg_we(wr && bus_addr == A_CFG),
    .ctl_we(wr && bus_addr == A_CTL),
    .wr_n  (bus_wdata[N_LSB +: NW]),
    .wr_m  (bus_wdata[MW-1:0]),
    .wr_en (bus_wdata[0]),
    .wr_cn (bus_wdata[1]),
    .apply (apply), .pd (pd_i), .lock (lock_i),
    .stg_n (stg_n), .stg_m (stg_m), .stg_en (stg_en), .stg_cn (stg_cn),
    .act_n (div_n_m1), .act_m (mul_m_m1),
    .act_en(syn_en), .act_cn (syn_connect)
  );

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      A_SRC: rd_next[1:0] = src_sel;
      A_CFG: begin
        rd_next[MW-1:0]      = stg_m;
        rd_next[N_LSB +: NW] = stg_n;
      end
      A_CTL: rd_next[1:0] = {stg_cn, stg_en};
      A_STAT: begin
        rd_next[MW-1:0]      = mul_m_m1;
        rd_next[N_LSB +: NW] = div_n_m1;
        rd_next[EN_BIT]      = syn_en;
        rd_next[CN_BIT]      = syn_connect;
        rd_next[LK_BIT]      = lock_i;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we) bus_rdata <= rd_next;
    end
  end

  a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);
  a_r4_staged_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == A_KEY) |=> ($stable(div_n_m1) && $stable(mul_m_m1)));
  a_r5_run_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syn_en) |-> $past(wr && bus_addr == A_KEY && bus_wdata[7:0] == KEY_SECOND));
endmodule

// File: tb/clkctl_regs_bench.sv
module clkctl_regs_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        req;
    logic        we;
    logic [2:0]  addr;
    logic [31:0] wd;
    logic        lock;
    logic        pd;
    logic [1:0]  src;
    logic [7:0]  n;
    logic [14:0] m;
    logic        en;
    logic        cn;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1,1'b1,3'd0,32'h1,       1'b0,1'b0,2'd1,8'h00,15'h0000,1'b0,1'b0,4'd2},  // R2 main osc
    '{1'b1,1'b1,3'd0,32'h3,       1'b0,1'b0,2'd1,8'h00,15'h0000,1'b0,1'b0,4'd3},  // R3 code 3 ignored
    '{1'b1,1'b1,3'd1,32'h0004001F,1'b0,1'b0,2'd1,8'h00,15'h0000,1'b0,1'b0,4'd4},  // R4 cfg staged
    '{1'b1,1'b1,3'd2,32'h1,       1'b0,1'b0,2'd1,8'h00,15'h0000,1'b0,1'b0,4'd4},  // R4 ctl staged
    '{1'b1,1'b1,3'd3,32'hAA,      1'b0,1'b0,2'd1,8'h00,15'h0000,1'b0,1'b0,4'd5},
    '{1'b1,1'b1,3'd3,32'h55,      1'b0,1'b0,2'd1,8'h04,15'h001F,1'b1,1'b0,4'd5},  // R5 applied
    '{1'b1,1'b1,3'd2,32'h3,       1'b0,1'b0,2'd1,8'h04,15'h001F,1'b1,1'b0,4'd4},
    '{1'b1,1'b1,3'd3,32'hAA,      1'b0,1'b0,2'd1,8'h04,15'h001F,1'b1,1'b0,4'd7},
    '{1'b1,1'b1,3'd3,32'h55,      1'b0,1'b0,2'd1,8'h04,15'h001F,1'b1,1'b0,4'd7},  // R7 no lock
    '{1'b1,1'b1,3'd3,32'hAA,      1'b1,1'b0,2'd1,8'h04,15'h001F,1'b1,1'b0,4'd7},
    '{1'b1,1'b1,3'd3,32'h55,      1'b1,1'b0,2'd1,8'h04,15'h001F,1'b1,1'b1,4'd7},  // R7 connect
    '{1'b1,1'b1,3'd1,32'h00FF7FFF,1'b1,1'b0,2'd1,8'h04,15'h001F,1'b1,1'b1,4'd4},
    '{1'b1,1'b1,3'd3,32'hAA,      1'b1,1'b0,2'd1,8'h04,15'h001F,1'b1,1'b1,4'd6},
    '{1'b1,1'b1,3'd0,32'h2,       1'b1,1'b0,2'd2,8'h04,15'h001F,1'b1,1'b1,4'd2},  // R2 rtc osc
    '{1'b1,1'b1,3'd3,32'h55,      1'b1,1'b0,2'd2,8'h04,15'h001F,1'b1,1'b1,4'd6},  // R6 broken
    '{1'b1,1'b1,3'd3,32'hAA,      1'b1,1'b0,2'd2,8'h04,15'h001F,1'b1,1'b1,4'd6},
    '{1'b1,1'b1,3'd3,32'h55,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b1,1'b1,4'd10}, // R10 max fields
    '{1'b0,1'b0,3'd0,32'h0,       1'b1,1'b1,2'd2,8'hFF,15'h7FFF,1'b0,1'b0,4'd8},  // R8 power-down
    '{1'b1,1'b1,3'd3,32'hAA,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b0,1'b0,4'd8},
    '{1'b1,1'b1,3'd3,32'h55,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b0,1'b0,4'd8},  // R8 stays off
    '{1'b1,1'b1,3'd2,32'h3,       1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b0,1'b0,4'd4},
    '{1'b1,1'b1,3'd3,32'hAA,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b0,1'b0,4'd7},
    '{1'b1,1'b1,3'd3,32'h55,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b1,1'b0,4'd7},  // R7 run first
    '{1'b1,1'b1,3'd3,32'hAA,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b1,1'b0,4'd7},
    '{1'b1,1'b1,3'd3,32'h55,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b1,1'b1,4'd7},
    '{1'b1,1'b1,3'd2,32'h0,       1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b1,1'b1,4'd4},
    '{1'b1,1'b1,3'd3,32'hAA,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b1,1'b1,4'd6},
    '{1'b1,1'b0,3'd1,32'h0,       1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b1,1'b1,4'd6},  // R6 read between
    '{1'b1,1'b1,3'd3,32'h55,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b1,1'b1,4'd6},
    '{1'b1,1'b1,3'd3,32'hAA,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b1,1'b1,4'd5},
    '{1'b1,1'b1,3'd3,32'h55,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b0,1'b0,4'd5},
    '{1'b1,1'b1,3'd2,32'h1,       1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b0,1'b0,4'd4},
    '{1'b1,1'b1,3'd3,32'hAA,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b0,1'b0,4'd6},
    '{1'b1,1'b1,3'd3,32'h12,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b0,1'b0,4'd6},
    '{1'b1,1'b1,3'd3,32'h55,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b0,1'b0,4'd6},  // R6 wrong key
    '{1'b1,1'b1,3'd3,32'hAA,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b0,1'b0,4'd5},
    '{1'b1,1'b1,3'd3,32'h55,      1'b1,1'b0,2'd2,8'hFF,15'h7FFF,1'b1,1'b0,4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        lock_i = 1'b0, pd_i = 1'b0;
  logic [1:0]  src_sel;
  logic [7:0]  div_n_m1;
  logic [14:0] mul_m_m1;
  logic        syn_en, syn_connect;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkctl_regs u_clkctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .lock_i(lock_i), .pd_i(pd_i), .src_sel(src_sel),
    .div_n_m1(div_n_m1), .mul_m_m1(mul_m_m1), .syn_en(syn_en),
    .syn_connect(syn_connect)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic req, input logic we, input logic [2:0] a,
                      input logic [31:0] d);
    @(negedge clk);
    bus_req = req; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #(CLK_PERIOD/4);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [31:0] outs();
    return {4'd0, src_sel, div_n_m1, mul_m_m1, syn_en, syn_connect};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 reset outputs", outs(), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_req = VEC[i].req; bus_we = VEC[i].we; bus_addr = VEC[i].addr;
      bus_wdata = VEC[i].wd; lock_i = VEC[i].lock; pd_i = VEC[i].pd;
      @(posedge clk);
      #(CLK_PERIOD/4);
      check($sformatf("R%0d vector %0d", VEC[i].rq, i), outs(),
            {4'd0, VEC[i].src, VEC[i].n, VEC[i].m, VEC[i].en, VEC[i].cn});
    end
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; pd_i = 1'b0; lock_i = 1'b1;

    // R9 staged configuration readback, then rvalid drops on an idle cycle
    step(1'b1, 1'b0, 3'd1, 32'h0);
    check("R9 cfg read valid", {31'd0, bus_rvalid}, 32'd1);
    check("R9 cfg read", bus_rdata, 32'h00FF7FFF);
    @(posedge clk); #(CLK_PERIOD/4);
    check("R9 rvalid idle", {31'd0, bus_rvalid}, 32'd0);
    // R10 staged value differs from active, status shows active and lock
    step(1'b1, 1'b1, 3'd1, 32'h00030005);
    step(1'b1, 1'b0, 3'd1, 32'h0);
    check("R10 cfg staged readback", bus_rdata, 32'h00030005);
    step(1'b1, 1'b0, 3'd4, 32'h0);
    check("R9 status active", bus_rdata, 32'h05FF7FFF);
    step(1'b1, 1'b0, 3'd2, 32'h0);
    check("R9 ctl staged", bus_rdata, 32'h1);
    step(1'b1, 1'b0, 3'd0, 32'h0);
    check("R3 src read zero upper", bus_rdata, 32'h2);
    step(1'b1, 1'b1, 3'd0, 32'hFFFF_FFFC);
    check("R2 back to rc", {30'd0, src_sel}, 32'h0);
    check("R4 outputs unchanged", {8'd0, div_n_m1, mul_m_m1, syn_en}, {8'd0, 8'hFF, 15'h7FFF, 1'b1});

    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_PERIOD/4);
    check("R1 reset mid-run", outs(), 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule